// File: doc/BRIEF.md
# PWM-Dithered DAC Code Generator

This block drives a coarse 8-bit DAC so that, after an external low-pass filter, the averaged output approaches 16-bit resolution. Software writes a 16-bit level request through a single-cycle write strobe. The upper byte of the request is the base DAC code. The lower byte sets how many ticks in every 256-tick slice of a frame the code is raised by one step. Over a 256-tick frame the code sum therefore equals the request exactly.

The frame length is programmable through a second write strobe, with a floor of 256 clocks. Requests above 0xFF00 are clamped on entry, so the raised code never wraps past 0xFF, and mid-scale lands at 0x7F80. A new request or frame length is first held in a shadow copy. It is adopted only at the next frame start, so a frame never mixes two duty settings. A one-cycle frame marker accompanies the first code of every frame, so a consumer or checker can average over whole frames. When the enable input is low, the output code is forced to zero.

Top module: `pwm_dither_dac`

## Requirements
- R1: After reset the output code is 0x00 and the frame marker is low. The held request is 0x0000 and the held frame length is 256, so the first enabled frame is 256 ticks long and sums to 0.
- R2: A written request above 0xFF00 (0xFF01..0xFFFF) is stored as 0xFF00, which gives a constant code of 0xFF for the whole frame.
- R3: A written frame length below 256 is stored as 256. No two frame markers are ever fewer than 256 cycles apart.
- R4: A frame lasts exactly the adopted frame length, counted from one frame marker to the next.
- R5: At tick t of a frame (t = 0 at the marker), the code is base+1 when (t mod 256) < low byte and base otherwise, where base = request[15:8] and low byte = request[7:0].
- R6: With a 256-tick frame, the sum of the codes over one frame equals the 16-bit request.
- R7: A request written during a frame does not change that frame. It takes effect from the next frame marker.
- R8: While enable is low, the code is 0x00 and no marker appears. After enable goes high, the marker and the first code of a frame appear on the next cycle.
- R9: The request 0x7F80 gives exactly 128 ticks at 0x80 and 128 ticks at 0x7F in a 256-tick frame.
- R10: The frame marker is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces the code to zero and holds the frame counter |
| val_we | input | 1 | Write strobe for the level request |
| val_wdata | input | 16 | Level request; upper byte is the base code, lower byte the duty |
| per_we | input | 1 | Write strobe for the frame length |
| per_wdata | input | 16 | Frame length in clocks (minimum 256) |
| dac_code | output | 8 | Code driven to the coarse DAC |
| frame_start | output | 1 | One-cycle marker coinciding with the first code of a frame |

## Verification
Corrupted latched state shows up within one frame. A wrong duty or base changes the per-frame code sum and the count of raised ticks. A wrong frame counter moves the next marker off the expected cycle. A broken clamp or shadow register shows up in the first frame after it is adopted, either as a code of 0x00 from a wrapped base+1 or as a sum that belongs to the wrong request. Frames are measured whole, from one marker to the next. Writes made mid-frame are checked against the frame already in progress, so a premature adoption shows up in that same frame.

// File: rtl/dd_pkg.sv
package dd_pkg;
    localparam int unsigned CODE_W = 8;
    localparam int unsigned FRAC_W = 8;
    localparam int unsigned VAL_W  = CODE_W + FRAC_W;
    localparam int unsigned PER_W  = 16;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [VAL_W-1:0]  val_t;
    typedef logic [PER_W-1:0]  per_t;

    // smallest legal frame: one full slice of the fraction range
    localparam per_t PER_MIN = per_t'(1 << FRAC_W);
    // largest legal request: top code, zero fraction
    localparam val_t VAL_MAX = {{CODE_W{1'b1}}, {FRAC_W{1'b0}}};

    typedef struct packed {
        val_t val;
        per_t per;
    } shadow_t;

    typedef struct packed {
        per_t cnt;
        per_t per;
    } timer_t;

    typedef struct packed {
        val_t  val;
        code_t code;
        logic  fs;
    } out_t;
endpackage

// File: rtl/dd_shadow_regs.sv
module dd_shadow_regs
    import dd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic val_we,
    input  val_t val_wdata,
    input  logic per_we,
    input  per_t per_wdata,
    output val_t sh_val,
    output per_t sh_per
);
    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (val_we) begin
            s_d.val = (val_wdata > VAL_MAX) ? VAL_MAX : val_wdata;
        end
        if (per_we) begin
            s_d.per = (per_wdata < PER_MIN) ? PER_MIN : per_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{val: '0, per: PER_MIN};
        end else begin
            s_q <= s_d;
        end
    end

    assign sh_val = s_q.val;
    assign sh_per = s_q.per;
endmodule

// File: rtl/dd_frame_timer.sv
module dd_frame_timer
    import dd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  per_t sh_per,
    output per_t tick,
    output logic frame_go
);
    timer_t t_d, t_q;

    // a frame begins whenever the counter rests at zero while running
    assign frame_go = en && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (!en) begin
            t_d.cnt = '0;
        end else if (frame_go) begin
            t_d.per = sh_per;
            t_d.cnt = per_t'(1);
        end else if (t_q.cnt == t_q.per - per_t'(1)) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + per_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{cnt: '0, per: PER_MIN};
        end else begin
            t_q <= t_d;
        end
    end

    assign tick = t_q.cnt;
endmodule

// File: rtl/dd_level_sel.sv
module dd_level_sel
    import dd_pkg::*;
(
    input  val_t  val,
    input  per_t  tick,
    output code_t code
);
    code_t base;
    frac_t frac;
    frac_t slice;

    always_comb begin
        base  = val[VAL_W-1:FRAC_W];
        frac  = val[FRAC_W-1:0];
        slice = tick[FRAC_W-1:0];
        code  = (slice < frac) ? code_t'(base + code_t'(1)) : base;
    end
endmodule

// File: rtl/pwm_dither_dac.sv
module pwm_dither_dac
    import dd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        val_we,
    input  logic [15:0] val_wdata,
    input  logic        per_we,
    input  logic [15:0] per_wdata,
    output logic [7:0]  dac_code,
    output logic        frame_start
);
    val_t  sh_val;
    per_t  sh_per;
    per_t  tick;
    logic  frame_go;
    val_t  sel_val;
    code_t sel_code;
    out_t  o_d, o_q;

    dd_shadow_regs u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .val_we    (val_we),
        .val_wdata (val_t'(val_wdata)),
        .per_we    (per_we),
        .per_wdata (per_t'(per_wdata)),
        .sh_val    (sh_val),
        .sh_per    (sh_per)
    );

    dd_frame_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sh_per   (sh_per),
        .tick     (tick),
        .frame_go (frame_go)
    );

    // at a frame start the fresh request is used directly for tick 0
    assign sel_val = frame_go ? sh_val : o_q.val;

    dd_level_sel u_sel (
        .val  (sel_val),
        .tick (tick),
        .code (sel_code)
    );

    always_comb begin
        o_d = o_q;
        if (!en) begin
            o_d.code = '0;
            o_d.fs   = 1'b0;
        end else begin
            o_d.code = sel_code;
            o_d.fs   = frame_go;
            if (frame_go) begin
                o_d.val = sh_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '{val: '0, code: '0, fs: 1'b0};
        end else begin
            o_q <= o_d;
        end
    end

    assign dac_code    = o_q.code;
    assign frame_start = o_q.fs;
endmodule

// File: rtl/dd_checker.sv
module dd_checker
    import dd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic [7:0]  dac_code,
    input logic        frame_start
);
    logic        seen_q;
    logic [16:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            if (!en) begin
                seen_q <= 1'b0;
            end else if (frame_start) begin
                seen_q <= 1'b1;
            end
            if (frame_start) begin
                gap_q <= 17'd1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 17'd1;
            end
        end
    end

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dac_code == 8'h00 && !frame_start)); // R8

    AST_FS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(en)); // R8

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !frame_start) |->
            (dac_code == $past(dac_code) ||
             dac_code == 8'($past(dac_code) + 8'd1) ||
             8'(dac_code + 8'd1) == $past(dac_code))); // R5

    AST_FRAME_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && seen_q) |-> (gap_q >= 17'd256)); // R3
endmodule

bind pwm_dither_dac dd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .dac_code    (dac_code),
    .frame_start (frame_start)
);

// File: tb/tb_pwm_dither_dac.sv
module tb_pwm_dither_dac;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        val_we = 1'b0;
    logic [15:0] val_wdata = '0;
    logic        per_we = 1'b0;
    logic [15:0] per_wdata = '0;
    logic [7:0]  dac_code;
    logic        frame_start;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dither_dac dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .val_we      (val_we),
        .val_wdata   (val_wdata),
        .per_we      (per_we),
        .per_wdata   (per_wdata),
        .dac_code    (dac_code),
        .frame_start (frame_start)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic write_val(input logic [15:0] v);
        val_we = 1'b1; val_wdata = v;
        @(negedge clk);
        val_we = 1'b0;
    endtask

    task automatic write_per(input logic [15:0] p);
        per_we = 1'b1; per_wdata = p;
        @(negedge clk);
        per_we = 1'b0;
    endtask

    function automatic int model_hi(input int per, input int frac);
        int n = 0;
        for (int t = 0; t < per; t++) if ((t % 256) < frac) n++;
        return n;
    endfunction

    // measure one whole frame from a marker to the next marker
    task automatic measure(input int b, output int sum, output int len,
                           output int hi, output int odd, output int first);
        sum = 0; len = 0; hi = 0; odd = 0;
        while (frame_start !== 1'b1) @(negedge clk);
        first = dac_code;
        do begin
            sum += dac_code;
            len++;
            if (dac_code == b + 1) hi++;
            else if (dac_code != b) odd++;
            @(negedge clk);
        end while (frame_start !== 1'b1);
    endtask

    // discard the frame that may straddle a write, then measure
    task automatic settle_measure(input int b, output int sum, output int len,
                                  output int hi, output int odd, output int first);
        int s0, l0, h0, o0, f0;
        measure(b, s0, l0, h0, o0, f0);
        measure(b, sum, len, hi, odd, first);
    endtask

    task automatic t_reset;
        int sum, len, hi, odd, first;
        rst_n = 1'b0; en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_code == 8'h00, "R1", "code after reset", dac_code, 0);
        check(frame_start == 1'b0, "R1", "marker after reset", frame_start, 0);
        en = 1'b1;
        measure(0, sum, len, hi, odd, first);
        check(len == 256, "R1", "default frame length", len, 256);
        check(sum == 0, "R1", "default frame sum", sum, 0);
    endtask

    task automatic t_value(input logic [15:0] v);
        int sum, len, hi, odd, first, b, f;
        b = int'(v[15:8]); f = int'(v[7:0]);
        write_val(v);
        settle_measure(b, sum, len, hi, odd, first);
        check(sum == int'(v), "R6", "frame sum", sum, int'(v));
        check(hi == f && odd == 0, "R5", "raised ticks", hi, f);
        check(first == ((f > 0) ? b + 1 : b), "R5", "tick0 code", first,
              (f > 0) ? b + 1 : b);
        check(len == 256, "R10", "marker spacing (single pulse)", len, 256);
    endtask

    task automatic t_midscale;
        int sum, len, hi, odd, first;
        write_val(16'h7F80);
        settle_measure(8'h7F, sum, len, hi, odd, first);
        check(hi == 128, "R9", "ticks at 0x80", hi, 128);
        check(len - hi == 128 && odd == 0, "R9", "ticks at 0x7F", len - hi, 128);
    endtask

    task automatic t_clamp(input logic [15:0] v);
        int sum, len, hi, odd, first;
        write_val(v);
        settle_measure(8'hFF, sum, len, hi, odd, first);
        check(sum == 16'hFF00, "R2", "clamped sum", sum, 16'hFF00);
        check(hi == 0 && odd == 0, "R2", "non-0xFF ticks", hi + odd, 0);
    endtask

    task automatic t_period(input logic [15:0] p, input int exp_len,
                            input logic [15:0] v, input string req);
        int sum, len, hi, odd, first, b, f, eh;
        b = int'(v[15:8]); f = int'(v[7:0]);
        write_val(v);
        write_per(p);
        settle_measure(b, sum, len, hi, odd, first);
        eh = model_hi(exp_len, f);
        check(len == exp_len, req, "frame length", len, exp_len);
        check(hi == eh && odd == 0, "R5", "raised ticks in long frame", hi, eh);
        check(sum == exp_len * b + eh, "R5", "long frame sum", sum, exp_len * b + eh);
    endtask

    task automatic t_midwrite(input logic [15:0] a, input logic [15:0] bv);
        int sum, len, hi, odd, first;
        write_per(16'd256);
        write_val(a);
        settle_measure(int'(a[15:8]), sum, len, hi, odd, first);
        // now at a marker; run this frame and write mid-way
        sum = 0;
        for (int i = 0; i < 256; i++) begin
            sum += dac_code;
            if (i == 50) begin val_we = 1'b1; val_wdata = bv; end
            if (i == 51) val_we = 1'b0;
            @(negedge clk);
        end
        check(frame_start == 1'b1, "R7", "marker after frame", frame_start, 1);
        check(sum == int'(a), "R7", "frame with mid write", sum, int'(a));
        measure(int'(bv[15:8]), sum, len, hi, odd, first);
        check(sum == int'(bv), "R7", "next frame adopts write", sum, int'(bv));
    endtask

    task automatic t_enable;
        int bad_code = 0, bad_fs = 0;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (dac_code != 8'h00) bad_code++;
            if (frame_start) bad_fs++;
            @(negedge clk);
        end
        check(bad_code == 0, "R8", "nonzero codes while disabled", bad_code, 0);
        check(bad_fs == 0, "R8", "markers while disabled", bad_fs, 0);
        en = 1'b1;
        @(negedge clk);
        check(frame_start == 1'b1, "R8", "marker after enable", frame_start, 1);
        check(dac_code == 8'h2B, "R8", "first code after enable", dac_code, 8'h2B);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_value(16'h1234);
        t_value(16'h5600);
        t_value(16'h00FF);
        t_value(16'hFF00);
        t_midscale();
        t_clamp(16'hFFFF);
        t_clamp(16'hFF01);
        t_period(16'd100, 256, 16'h1040, "R3");
        t_period(16'd600, 600, 16'h1040, "R4");
        t_period(16'd0, 256, 16'h0381, "R3");
        t_midwrite(16'h4411, 16'h2A10);
        t_enable();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule